// File: doc/BRIEF.md
# Single-Channel Bus-Mastering DMA Controller

This block moves a block of words between system memory and one peripheral without the processor. The processor programs it as a slave: a start address, a word count, and a control word that selects the direction and the pacing mode. Setting the start bit in the control word launches the transfer.

Once launched, the controller raises a bus request and waits for the grant. While the grant is high it acts as bus master. For each word it drives the memory address and exactly one strobe: a read strobe for memory-to-peripheral, a write strobe for peripheral-to-memory. The peripheral paces the transfer one word at a time with its request line, and the controller answers each request with an acknowledge in the cycle that moves the word.

In single-word mode the bus is handed back after every word. In burst mode the bus is kept until the last word. When the count runs out, the controller releases the bus and raises an interrupt. A read of the status register clears that interrupt.

The shared strobe pins are modelled as split halves. `cpu_rd`/`cpu_wr` are the slave inputs, and `mem_rd`/`mem_wr` are the master outputs. `bus_drive` marks when the master side owns the address pins.

Top module: `dma_single_ch`

## Requirements
- R1: After reset, bus_req, irq, dev_ack, mem_rd, mem_wr and bus_drive are 0, and the address, count and status registers read 0.
- R2: Slave access happens only when cs=1 and bus_grant=0. rsel selects the register: 0 = address, 1 = word count, 2 = control, 3 = status. Control bit0 is direction (1 = memory-to-peripheral, 0 = peripheral-to-memory), bit1 is burst, bit2 is start. Status bit0 is done and bit1 is busy. cpu_rdata is valid in the cycle cpu_rd is high.
- R3: The controller never asserts mem_rd, mem_wr, dev_ack or bus_drive while bus_grant is 0.
- R4: In memory-to-peripheral mode, each word takes one cycle. In that cycle mem_rd=1, dev_ack=1, mem_addr holds the current address and dev_dout equals mem_rdata.
- R5: In peripheral-to-memory mode, each word takes one cycle. In that cycle mem_wr=1, dev_ack=1, mem_addr holds the current address and mem_wdata equals dev_din.
- R6: After each word the address increments by one, wrapping modulo 2^AW, and the count decrements by one.
- R7: In single-word mode, bus_req is 0 while waiting for a peripheral request and drops in the cycle after each word.
- R8: In burst mode, bus_req rises the cycle after the start command and stays 1 between words until the last word.
- R9: In the cycle after the last word, bus_req is 0, done is set and irq is 1.
- R10: A status read clears done and irq in the next cycle.
- R11: While busy, writes to any register are ignored, including a start command.
- R12: A start command with a word count of 0 sets done and irq in the next cycle and never raises bus_req.
- R13: mem_rd and mem_wr are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cs | input | 1 | Slave chip select |
| rsel | input | 2 | Register select |
| cpu_rd | input | 1 | Slave read strobe |
| cpu_wr | input | 1 | Slave write strobe |
| cpu_wdata | input | RW | Slave write data |
| cpu_rdata | output | RW | Slave read data |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_grant | input | 1 | Bus grant from the arbiter |
| bus_drive | output | 1 | Master owns address and strobes |
| mem_addr | output | AW | Memory address as master |
| mem_rd | output | 1 | Memory read strobe as master |
| mem_wr | output | 1 | Memory write strobe as master |
| mem_rdata | input | DW | Data read from memory |
| mem_wdata | output | DW | Data written to memory |
| dev_req | input | 1 | Peripheral word request |
| dev_ack | output | 1 | Peripheral acknowledge |
| dev_din | input | DW | Data from the peripheral |
| dev_dout | output | DW | Data to the peripheral |
| irq | output | 1 | Transfer-complete interrupt |

## Verification
The bench builds the block with AW=8, DW=8 and CW=4. The 8-bit address lets a three-word transfer started at 0xFE cross the wrap to 0x00. The small count keeps the zero-count start, the busy-time writes and both pacing modes short. A bench-side arbiter grants one half-cycle after each request, and a memory model checks both directions word by word.

// File: rtl/dma_single_ch.sv
module dma_single_ch #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 16,
  localparam int RW0 = (AW > CW) ? AW : CW,
  localparam int RW = (RW0 < 3) ? 3 : RW0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic [1:0]    rsel,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  input  logic [RW-1:0] cpu_wdata,
  output logic [RW-1:0] cpu_rdata,
  output logic          bus_req,
  input  logic          bus_grant,
  output logic          bus_drive,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] mem_wdata,
  input  logic          dev_req,
  output logic          dev_ack,
  input  logic [DW-1:0] dev_din,
  output logic [DW-1:0] dev_dout,
  output logic          irq
);

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_ARB, S_OWN, S_XFER} state_t;

  state_t        state;
  logic [AW-1:0] addr;
  logic [CW-1:0] cnt;
  logic          dir, burst, done;

  wire slv_wr    = cs & cpu_wr & ~bus_grant;
  wire slv_rd    = cs & cpu_rd & ~bus_grant;
  wire busy      = (state != S_IDLE);
  wire start_cmd = slv_wr && (rsel == 2'd2) && cpu_wdata[2] && !busy;
  wire last      = (cnt == CW'(1));
  wire xfer_on   = (state == S_XFER) & bus_grant;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      addr  <= '0;
      cnt   <= '0;
      dir   <= 1'b0;
      burst <= 1'b0;
      done  <= 1'b0;
    end else begin
      if (slv_wr && !busy) begin
        case (rsel)
          2'd0: addr <= cpu_wdata[AW-1:0];
          2'd1: cnt  <= cpu_wdata[CW-1:0];
          2'd2: begin dir <= cpu_wdata[0]; burst <= cpu_wdata[1]; end
          default: ;
        endcase
      end
      if (slv_rd && rsel == 2'd3) done <= 1'b0;
      if (start_cmd) begin
        done <= (cnt == '0);
        if (cnt != '0) state <= cpu_wdata[1] ? S_ARB : S_WAIT;
      end
      case (state)
        S_WAIT: if (dev_req) state <= S_ARB;
        S_ARB:  if (bus_grant) state <= burst ? S_OWN : S_XFER;
        S_OWN:  if (bus_grant && dev_req) state <= S_XFER;
        S_XFER: if (bus_grant) begin
          addr <= addr + AW'(1);
          cnt  <= cnt - CW'(1);
          if (last) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end else begin
            state <= burst ? S_OWN : S_WAIT;
          end
        end
        default: ;
      endcase
    end
  end

  assign bus_req   = (state == S_ARB) || (state == S_OWN) || (state == S_XFER);
  assign bus_drive = bus_grant && ((state == S_OWN) || (state == S_XFER));
  assign dev_ack   = xfer_on;
  assign mem_rd    = xfer_on & dir;
  assign mem_wr    = xfer_on & ~dir;
  assign mem_addr  = bus_drive ? addr : '0;
  assign mem_wdata = mem_wr ? dev_din : '0;
  assign dev_dout  = mem_rd ? mem_rdata : '0;
  assign irq       = done;

  always_comb begin
    cpu_rdata = '0;
    if (slv_rd) begin
      case (rsel)
        2'd0: cpu_rdata = RW'(addr);
        2'd1: cpu_rdata = RW'(cnt);
        2'd2: cpu_rdata = RW'({burst, dir});
        default: cpu_rdata = RW'({busy, done});
      endcase
    end
  end

  // R3
  no_drive_without_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr || dev_ack || bus_drive) |-> bus_grant);

  // R13
  rd_wr_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ack |=> (cnt == $past(cnt) - CW'(1)) && (addr == $past(addr) + AW'(1)));

  // R8
  burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_ack && burst && !last) |=> bus_req);

  // R9
  done_releases_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> !bus_req);

  // R12
  zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_cmd && cnt == '0) |=> (irq && !bus_req));

endmodule

// File: tb/test_dma_single_ch.sv
module test_dma_single_ch;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8, DW = 8, CW = 4, RW = 8;

  logic clk = 0, rst_n = 0;
  logic cs = 0, cpu_rd = 0, cpu_wr = 0, bus_grant = 0, dev_req = 0;
  logic [1:0] rsel = 0;
  logic [RW-1:0] cpu_wdata = 0, cpu_rdata;
  logic bus_req, bus_drive, mem_rd, mem_wr, dev_ack, irq;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata, mem_wdata, dev_din = 0, dev_dout;
  logic [DW-1:0] mem [256];
  int checks = 0, failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_single_ch #(.AW(AW), .DW(DW), .CW(CW)) i_dma_single_ch (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rsel(rsel), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .bus_req(bus_req), .bus_grant(bus_grant),
    .bus_drive(bus_drive), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_rdata(mem_rdata), .mem_wdata(mem_wdata), .dev_req(dev_req), .dev_ack(dev_ack),
    .dev_din(dev_din), .dev_dout(dev_dout), .irq(irq));

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_wr) mem[mem_addr] <= mem_wdata;
  always @(negedge clk) bus_grant <= bus_req;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [1:0] r, input logic [RW-1:0] d);
    @(negedge clk); cs = 1; cpu_wr = 1; rsel = r; cpu_wdata = d;
    @(negedge clk); cs = 0; cpu_wr = 0;
  endtask

  task automatic cpu_read(input logic [1:0] r, output logic [RW-1:0] d);
    @(negedge clk); cs = 1; cpu_rd = 1; rsel = r;
    #1 d = cpu_rdata;
    @(negedge clk); cs = 0; cpu_rd = 0;
  endtask

  task automatic do_word(input string req, input logic [AW-1:0] exp_addr, input bit to_dev);
    bit seen = 0;
    @(negedge clk); dev_req = 1;
    for (int i = 0; i < 20 && !seen; i++) begin
      @(negedge clk);
      if (dev_ack) seen = 1;
    end
    chk({req, " ack"}, seen, 1);
    chk({req, " addr R6"}, mem_addr, exp_addr);
    chk({req, " R13 rd"}, mem_rd, to_dev);
    chk({req, " R13 wr"}, mem_wr, !to_dev);
    chk({req, " R3 grant"}, bus_grant, 1);
    if (to_dev) chk({req, " R4 data"}, dev_dout, mem[exp_addr]);
    else chk({req, " R5 data"}, mem_wdata, dev_din);
    dev_req = 0;
  endtask

  task automatic t_reset;
    logic [RW-1:0] d;
    chk("R1 bus_req", bus_req, 0);
    chk("R1 irq", irq, 0);
    chk("R1 ack", dev_ack, 0);
    chk("R1 drive", bus_drive, 0);
    cpu_read(0, d); chk("R1 addr", d, 0);
    cpu_read(1, d); chk("R1 count", d, 0);
    cpu_read(3, d); chk("R1 status", d, 0);
  endtask

  task automatic t_zero_count;
    logic [RW-1:0] d;
    cpu_write(0, 8'h10);
    cpu_write(1, 8'h00);
    cpu_write(2, 8'b101);
    chk("R12 irq", irq, 1);
    chk("R12 bus_req", bus_req, 0);
    repeat (3) @(negedge clk);
    chk("R12 no request", bus_req, 0);
    cpu_read(3, d); chk("R2 status done", d, 8'h01);
    chk("R10 irq cleared", irq, 0);
  endtask

  task automatic t_mem_to_dev_single;
    logic [RW-1:0] d;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    cpu_write(0, 8'hFE);
    cpu_write(1, 8'h03);
    cpu_write(2, 8'b101);
    chk("R7 idle before request", bus_req, 0);
    chk("R3 no drive before grant", bus_drive, 0);
    do_word("R4 w0", 8'hFE, 1);
    @(negedge clk); chk("R7 drop after word", bus_req, 0);
    @(negedge clk);
    cpu_write(1, 8'h09);
    cpu_write(0, 8'h40);
    cpu_write(2, 8'b100);
    cpu_read(1, d); chk("R11 count kept", d, 8'h02);
    cpu_read(0, d); chk("R11 addr kept", d, 8'hFF);
    cpu_read(2, d); chk("R11 control kept", d, 8'h01);
    cpu_read(3, d); chk("R2 status busy", d, 8'h02);
    do_word("R4 w1", 8'hFF, 1);
    @(negedge clk); chk("R7 drop w1", bus_req, 0);
    do_word("R6 wrap w2", 8'h00, 1);
    @(negedge clk);
    chk("R9 bus_req", bus_req, 0);
    chk("R9 irq", irq, 1);
    @(negedge clk);
    cpu_read(0, d); chk("R6 final addr", d, 8'h01);
    cpu_read(1, d); chk("R6 final count", d, 8'h00);
    cpu_read(3, d); chk("R9 status done", d, 8'h01);
    chk("R10 irq cleared", irq, 0);
  endtask

  task automatic t_dev_to_mem_burst;
    logic [RW-1:0] d;
    cpu_write(0, 8'h20);
    cpu_write(1, 8'h04);
    cpu_write(2, 8'b110);
    chk("R8 request at start", bus_req, 1);
    for (int k = 0; k < 4; k++) begin
      dev_din = 8'hA0 + 8'(k);
      do_word("R5 burst", 8'h20 + 8'(k), 0);
      @(negedge clk);
      chk("R5 mem written", mem[8'h20 + 8'(k)], 8'hA0 + 8'(k));
      if (k < 3) begin
        @(negedge clk);
        chk("R8 bus held", bus_req, 1);
      end
    end
    chk("R9 burst release", bus_req, 0);
    chk("R9 burst irq", irq, 1);
    @(negedge clk);
    cpu_read(3, d); chk("R10 status", d, 8'h01);
    chk("R10 irq low", irq, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_zero_count;
    t_mem_to_dev_single;
    t_dev_to_mem_burst;
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule